// File: doc/BRIEF.md
# Servo Gate Ramp Controller

This block drives a hobby-servo style actuator that swings a barrier between a closed and an open position. It emits a fixed-period pulse stream and changes the pulse width a little at the end of every frame, so the arm moves at a controlled pace instead of jumping. A step input sets that pace. Two limit inputs set the end positions, and the block clamps to whichever limit the ramp reaches.

When a ramp ends, the block keeps sending frames at the final width for a short run-on period, which lets the servo settle, and then holds the pin low. A two-colour indicator blinks red while the arm travels and shows solid red when it is closed or solid green when it is open. Timing runs on a 1 us tick enable. Button debouncing and trim measurement are done outside the block.

Top module: `servo_gate_ramp`

## Requirements
- R1: A frame lasts FRAME_US ticks (default 20000). At the start of a frame `servo_pwm` goes high for exactly the current width in ticks and stays low for the rest of the frame, so high time plus low time always equals FRAME_US.
- R2: The width never leaves MIN_US..MAX_US (default 900..2100). The closed limit in use is `closed_lim` raised to MIN_US if it is below it, and the open limit in use is `open_lim` lowered to MAX_US if it is above it.
- R3: While `rst` is high, `servo_pwm` is low, `led_red` is 1 and `led_green` is 0. After reset the width is MID_US (default 1500) and the gate ramps upward at once.
- R4: While moving, at each frame end the width grows by `step_us` when opening and shrinks by `step_us` when closing.
- R5: When opening, if width plus step is at or above the open limit, the width becomes exactly the open limit, movement stops, `led_green`=1 and `led_red`=0.
- R6: When closing, if width minus step is strictly below the closed limit, the width becomes exactly the closed limit, movement stops, `led_red`=1 and `led_green`=0. Landing exactly on the limit keeps the gate moving.
- R7: After a ramp ends, RUNON_FRAMES frames (default 25) are sent at the final width, counting the frame that starts at the stop. After that `servo_pwm` stays low until the next start.
- R8: While moving, `led_green` is 0. `led_red` is set to 1 when a movement starts and toggles at the end of every BLINK_FRAMES-th frame (default 12) of travel.
- R9: A `dn_req` pulse selects closing and an `up_req` pulse selects opening. If both are high together, closing wins. During a ramp a request only changes the direction. During run-on it restarts movement without breaking the frame. When the output is off it starts a new frame on the next cycle.
- R10: A `lim_upd` pulse while the gate is stopped and the output is off moves the width to the open limit if the width is at or above MID_US, and otherwise to the closed limit. It then sends ADJ_FRAMES frames (default 10) and stops, with the LEDs unchanged. At any other time the pulse has no effect.
- R11: A new width takes effect only at a frame start. Every frame's pulse has a single, uninterrupted width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | 1 us time-base enable |
| up_req | input | 1 | Open request pulse (debounced) |
| dn_req | input | 1 | Close request pulse (debounced) |
| closed_lim | input | POS_W | Closed-position width in ticks |
| open_lim | input | POS_W | Open-position width in ticks |
| step_us | input | STEP_W | Width change per frame while moving, at least 1 |
| lim_upd | input | 1 | Pulse marking new limit values |
| servo_pwm | output | 1 | Registered servo pulse |
| led_red | output | 1 | Registered red indicator drive |
| led_green | output | 1 | Registered green indicator drive |

## Verification
A request or limit strobe sampled at a clock edge starts a frame one cycle later when the output is off: the pulse rises on the next edge and lasts exactly the width in ticks. Width changes, stops and LED changes are registered at the frame-end edge, so they appear one cycle before the next pulse rises. The bench therefore records the LED state on the falling edge where each pulse rise is first seen, measures each pulse's high run in cycles, and compares the frames in order against a list computed from the requirements. Mid-ramp requests are issued just after a pulse rise, well clear of the frame-end edge, and each case waits two idle frames beyond the expected count, which shows the output has stopped.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

  // Frame-end happenings reported by the ramp controller to the indicator.
  typedef struct packed {
    logic start;     // movement begins
    logic stepped;   // one travel frame completed without reaching a limit
    logic hit_open;  // ramp clamped at the open limit
    logic hit_shut;  // ramp clamped at the closed limit
  } ramp_evt_t;

endpackage

// File: rtl/sgr_frame_timer.sv
module sgr_frame_timer #(
  parameter int POS_W    = 15,
  parameter int FRAME_US = 20000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             out_en,
  input  logic [POS_W-1:0] width,
  output logic             frame_end,
  output logic             pulse
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_US - 1);

  logic [POS_W-1:0] cnt;

  assign frame_end = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      if (restart)        cnt <= '0;
      else if (frame_end) cnt <= '0;
      else if (tick)      cnt <= cnt + 1'b1;
      if (tick) pulse <= out_en && (cnt < width);
    end
  end

  // R1: the tick position never leaves the frame
  p_cnt_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  // R1: a pulse only ever begins at the first tick of a frame
  p_rise_at_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> (cnt == POS_W'(1)));

endmodule

// File: rtl/sgr_ramp_ctrl.sv
module sgr_ramp_ctrl
  import sgr_pkg::*;
#(
  parameter int POS_W        = 15,
  parameter int STEP_W       = 8,
  parameter int MID_US       = 1500,
  parameter int MIN_US       = 900,
  parameter int MAX_US       = 2100,
  parameter int RUNON_FRAMES = 25,
  parameter int ADJ_FRAMES   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              up_req,
  input  logic              dn_req,
  input  logic              lim_upd,
  input  logic [POS_W-1:0]  closed_lim,
  input  logic [POS_W-1:0]  open_lim,
  input  logic [STEP_W-1:0] step_us,
  output logic [POS_W-1:0]  width,
  output logic              out_en,
  output logic              restart,
  output ramp_evt_t         evt
);
  localparam int RUN_MAX = (RUNON_FRAMES > ADJ_FRAMES) ? RUNON_FRAMES : ADJ_FRAMES;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam logic [POS_W-1:0] MID_W = POS_W'(MID_US);
  localparam logic [POS_W-1:0] MIN_W = POS_W'(MIN_US);
  localparam logic [POS_W-1:0] MAX_W = POS_W'(MAX_US);
  localparam logic [RUN_W-1:0] RUNON_N = RUN_W'(RUNON_FRAMES);
  localparam logic [RUN_W-1:0] ADJ_N   = RUN_W'(ADJ_FRAMES);

  logic             moving, dir_up;
  logic [RUN_W-1:0] run_cnt;

  logic             n_moving, n_dir_up, n_out_en;
  logic [RUN_W-1:0] n_run_cnt;
  logic [POS_W-1:0] n_width;

  logic [POS_W-1:0] closed_eff, open_eff;
  logic [POS_W:0]   step_x, sum_up, diff_dn;
  logic             up_hit, dn_hit, any_req;

  assign closed_eff = (closed_lim < MIN_W) ? MIN_W : closed_lim;
  assign open_eff   = (open_lim > MAX_W)   ? MAX_W : open_lim;
  assign step_x     = {{(POS_W + 1 - STEP_W){1'b0}}, step_us};
  assign sum_up     = {1'b0, width} + step_x;
  assign diff_dn    = {1'b0, width} - step_x;
  assign up_hit     = sum_up >= {1'b0, open_eff};
  assign dn_hit     = diff_dn[POS_W] || (diff_dn[POS_W-1:0] < closed_eff);
  assign any_req    = up_req || dn_req;

  always_comb begin
    n_moving  = moving;
    n_dir_up  = dir_up;
    n_out_en  = out_en;
    n_run_cnt = run_cnt;
    n_width   = width;
    restart   = 1'b0;
    evt       = '0;

    if (frame_end && out_en) begin
      if (moving) begin
        if (dir_up && up_hit) begin
          n_width      = open_eff;
          n_moving     = 1'b0;
          n_run_cnt    = RUNON_N;
          evt.hit_open = 1'b1;
        end else if (!dir_up && dn_hit) begin
          n_width      = closed_eff;
          n_moving     = 1'b0;
          n_run_cnt    = RUNON_N;
          evt.hit_shut = 1'b1;
        end else begin
          n_width     = dir_up ? sum_up[POS_W-1:0] : diff_dn[POS_W-1:0];
          evt.stepped = 1'b1;
        end
      end else if (run_cnt <= RUN_W'(1)) begin
        n_out_en  = 1'b0;
        n_run_cnt = '0;
      end else begin
        n_run_cnt = run_cnt - 1'b1;
      end
    end

    if (any_req) begin
      n_dir_up = !dn_req;
      if (!moving) begin
        n_moving  = 1'b1;
        n_out_en  = 1'b1;
        evt.start = 1'b1;
        restart   = !out_en;
      end
    end else if (lim_upd && !moving && !out_en) begin
      n_width   = (width >= MID_W) ? open_eff : closed_eff;
      n_run_cnt = ADJ_N;
      n_out_en  = 1'b1;
      restart   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      moving  <= 1'b1;
      dir_up  <= 1'b1;
      out_en  <= 1'b1;
      run_cnt <= '0;
      width   <= MID_W;
    end else begin
      moving  <= n_moving;
      dir_up  <= n_dir_up;
      out_en  <= n_out_en;
      run_cnt <= n_run_cnt;
      width   <= n_width;
    end
  end

  // R2: width stays inside the mechanical window
  p_width_window_r2: assert property (@(posedge clk) disable iff (rst)
    (width >= MIN_W) && (width <= MAX_W));
  // R11: width moves only on a frame end or a fresh frame start
  p_width_at_frame_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(width) |-> $past(frame_end || restart));
  // R9: travel always has a live output
  p_moving_driven_r9: assert property (@(posedge clk) disable iff (rst)
    moving |-> out_en);
  // R5: an opening overshoot lands exactly on the open limit and stops
  p_open_clamp_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_end && out_en && moving && dir_up && up_hit && !any_req)
      |=> (!moving && (width == $past(open_eff))));
  // R6: a closing undershoot lands exactly on the closed limit and stops
  p_shut_clamp_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_end && out_en && moving && !dir_up && dn_hit && !any_req)
      |=> (!moving && (width == $past(closed_eff))));

endmodule

// File: rtl/sgr_led_ind.sv
module sgr_led_ind
  import sgr_pkg::*;
#(
  parameter int BLINK_FRAMES = 12
) (
  input  logic      clk,
  input  logic      rst,
  input  ramp_evt_t evt,
  output logic      led_red,
  output logic      led_green
);
  localparam int BC_W = $clog2(BLINK_FRAMES + 1);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(BLINK_FRAMES - 1);

  logic [BC_W-1:0] blink_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      led_red   <= 1'b1;
      led_green <= 1'b0;
      blink_cnt <= BC_LAST;
    end else if (evt.start) begin
      led_red   <= 1'b1;
      led_green <= 1'b0;
      blink_cnt <= BC_LAST;
    end else if (evt.hit_open) begin
      led_red   <= 1'b0;
      led_green <= 1'b1;
    end else if (evt.hit_shut) begin
      led_red   <= 1'b1;
      led_green <= 1'b0;
    end else if (evt.stepped) begin
      led_green <= 1'b0;
      if (blink_cnt == '0) begin
        led_red   <= !led_red;
        blink_cnt <= BC_LAST;
      end else begin
        blink_cnt <= blink_cnt - 1'b1;
      end
    end
  end

  // R8: the two colours are never driven together
  p_one_colour_r8: assert property (@(posedge clk) disable iff (rst)
    !(led_red && led_green));
  // R5: green only lights after an open clamp
  p_green_from_open_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(led_green) |-> $past(evt.hit_open));

endmodule

// File: rtl/servo_gate_ramp.sv
module servo_gate_ramp
  import sgr_pkg::*;
#(
  parameter int POS_W        = 15,
  parameter int STEP_W       = 8,
  parameter int FRAME_US     = 20000,
  parameter int MID_US       = 1500,
  parameter int MIN_US       = 900,
  parameter int MAX_US       = 2100,
  parameter int RUNON_FRAMES = 25,
  parameter int ADJ_FRAMES   = 10,
  parameter int BLINK_FRAMES = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_us,
  input  logic              up_req,
  input  logic              dn_req,
  input  logic [POS_W-1:0]  closed_lim,
  input  logic [POS_W-1:0]  open_lim,
  input  logic [STEP_W-1:0] step_us,
  input  logic              lim_upd,
  output logic              servo_pwm,
  output logic              led_red,
  output logic              led_green
);
  logic             frame_end, restart, out_en;
  logic [POS_W-1:0] width;
  ramp_evt_t        evt;

  sgr_frame_timer #(.POS_W(POS_W), .FRAME_US(FRAME_US)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_us), .restart(restart),
    .out_en(out_en), .width(width), .frame_end(frame_end), .pulse(servo_pwm)
  );

  sgr_ramp_ctrl #(
    .POS_W(POS_W), .STEP_W(STEP_W), .MID_US(MID_US), .MIN_US(MIN_US),
    .MAX_US(MAX_US), .RUNON_FRAMES(RUNON_FRAMES), .ADJ_FRAMES(ADJ_FRAMES)
  ) u_ramp (
    .clk(clk), .rst(rst), .frame_end(frame_end), .up_req(up_req),
    .dn_req(dn_req), .lim_upd(lim_upd), .closed_lim(closed_lim),
    .open_lim(open_lim), .step_us(step_us), .width(width),
    .out_en(out_en), .restart(restart), .evt(evt)
  );

  sgr_led_ind #(.BLINK_FRAMES(BLINK_FRAMES)) u_led (
    .clk(clk), .rst(rst), .evt(evt), .led_red(led_red), .led_green(led_green)
  );

endmodule

// File: tb/servo_gate_ramp_test.sv
module servo_gate_ramp_test;
  localparam int FR = 300, MIDW = 150, MINW = 90, MAXW = 210;
  localparam int RO = 4, AJ = 3, BL = 3;

  logic clk = 1'b0, rst = 1'b1, tick_us = 1'b1;
  logic up_req = 1'b0, dn_req = 1'b0, lim_upd = 1'b0;
  logic [14:0] closed_lim = 15'd100, open_lim = 15'd200;
  logic [7:0]  step_us = 8'd7;
  logic servo_pwm, led_red, led_green;

  servo_gate_ramp #(
    .FRAME_US(FR), .MID_US(MIDW), .MIN_US(MINW), .MAX_US(MAXW),
    .RUNON_FRAMES(RO), .ADJ_FRAMES(AJ), .BLINK_FRAMES(BL)
  ) uut (
    .clk(clk), .rst(rst), .tick_us(tick_us), .up_req(up_req), .dn_req(dn_req),
    .closed_lim(closed_lim), .open_lim(open_lim), .step_us(step_us),
    .lim_upd(lim_upd), .servo_pwm(servo_pwm), .led_red(led_red),
    .led_green(led_green)
  );

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  // frame capture
  int cap_w [0:1023];
  bit cap_r [0:1023];
  bit cap_g [0:1023];
  int cap_n = 0, cap_rises = 0, run_len = 0;
  logic prev_p = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (servo_pwm && !prev_p) begin
        if (cap_n < 1024) begin
          cap_r[cap_n] = led_red;
          cap_g[cap_n] = led_green;
        end
        run_len = 1;
        cap_rises++;
      end else if (servo_pwm) begin
        run_len++;
      end
      if (!servo_pwm && prev_p) begin
        if (cap_n < 1024) cap_w[cap_n] = run_len;
        cap_n++;
      end
      prev_p = servo_pwm;
    end
  end

  // expected frames
  int exp_w [0:255];
  bit exp_r [0:255];
  bit exp_g [0:255];
  int n_exp = 0, last_w = MIDW;
  bit cur_red = 1, cur_green = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 190000);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Frame list from the requirements (R4..R10).
  task automatic model(input bit adj, input bit up0, input int w0, input int cl,
                       input int op, input int st, input int evf, input bit evup);
    int clE, opE, w, s, run, bc, n;
    bit mv, up, r, g;
    clE = (cl < MINW) ? MINW : cl;
    opE = (op > MAXW) ? MAXW : op;
    n = 0; bc = BL - 1; up = up0;
    if (adj) begin
      w = (w0 >= MIDW) ? opE : clE; mv = 0; run = AJ; r = cur_red; g = cur_green;
    end else begin
      w = w0; mv = 1; run = 0; r = 1; g = 0;
    end
    while (n < 256) begin
      exp_w[n] = w; exp_r[n] = r; exp_g[n] = g;
      if (n == evf) begin
        up = evup;
        if (!mv) begin mv = 1; r = 1; g = 0; bc = BL - 1; end
      end
      n++;
      if (mv) begin
        s = up ? w + st : w - st;
        if (up && s >= opE) begin w = opE; mv = 0; g = 1; r = 0; run = RO; end
        else if (!up && s < clE) begin w = clE; mv = 0; r = 1; g = 0; run = RO; end
        else begin
          w = s;
          if (bc == 0) begin r = !r; bc = BL - 1; end else bc--;
        end
      end else begin
        run--;
        if (run == 0) break;
      end
    end
    n_exp = n; last_w = w; cur_red = r; cur_green = g;
  endtask

  // kind: 0 reset release, 1 request, 2 limit strobe, 3 both requests
  task automatic run_case(input string tag, input int kind, input bit up0,
                          input int cl, input int op, input int st,
                          input int evf, input bit evup, input int sa);
    int base_n, base_r, total;
    bit ev_done, sa_done;
    @(negedge clk);
    closed_lim = 15'(cl); open_lim = 15'(op); step_us = 8'(st);
    model(kind == 2, (kind == 3) ? 1'b0 : up0, last_w, cl, op, st, evf, evup);
    base_n = cap_n; base_r = cap_rises; ev_done = 0; sa_done = 0;
    if (kind == 0) rst = 1'b0;
    else if (kind == 1) begin if (up0) up_req = 1'b1; else dn_req = 1'b1; end
    else if (kind == 2) lim_upd = 1'b1;
    else begin up_req = 1'b1; dn_req = 1'b1; end
    total = (n_exp + 2) * FR + 20;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      up_req = 1'b0; dn_req = 1'b0; lim_upd = 1'b0;
      if (!ev_done && evf >= 0 && (cap_rises - base_r) == evf + 1) begin
        ev_done = 1;
        if (evup) up_req = 1'b1; else dn_req = 1'b1;
      end else if (!sa_done && sa >= 0 && (cap_rises - base_r) == sa + 1) begin
        sa_done = 1;
        lim_upd = 1'b1;  // R10: ignored while output is live
      end
    end
    chk((cap_n - base_n) == n_exp, {tag, " R7 frame count"}, cap_n - base_n, n_exp);
    for (int k = 0; k < n_exp && k < (cap_n - base_n); k++) begin
      chk(cap_w[base_n + k] == exp_w[k], {tag, " R1/R4 width"}, cap_w[base_n + k], exp_w[k]);
      chk(cap_r[base_n + k] == exp_r[k], {tag, " R8 red"}, cap_r[base_n + k], exp_r[k]);
      chk(cap_g[base_n + k] == exp_g[k], {tag, " R8 green"}, cap_g[base_n + k], exp_g[k]);
    end
    chk(servo_pwm == 1'b0, {tag, " R7 idle low"}, servo_pwm, 0);
    chk(led_red == cur_red, {tag, " R5/R6 final red"}, led_red, cur_red);
    chk(led_green == cur_green, {tag, " R5/R6 final green"}, led_green, cur_green);
  endtask

  initial begin
    int rv, cl, op, st, evf, sa;
    bit up, evup;
    rv = $urandom(32'd2718);
    repeat (5) @(negedge clk);
    // R3: reset state
    chk(servo_pwm == 1'b0, "R3 pwm in reset", servo_pwm, 0);
    chk(led_red == 1'b1, "R3 red in reset", led_red, 1);
    chk(led_green == 1'b0, "R3 green in reset", led_green, 0);
    // R3 upward ramp from the midpoint, R5 overshoot clamp
    run_case("reset", 0, 1, 100, 200, 7, -1, 0, -1);
    // R6 close ramp; repeated down request is only a direction write (R9)
    run_case("close", 1, 0, 100, 200, 9, 1, 0, -1);
    // R5 exact arrival at open, then R6 exact landing keeps moving
    run_case("exact_up", 1, 1, 100, 200, 25, -1, 0, -1);
    run_case("exact_dn", 1, 0, 100, 200, 25, -1, 0, -1);
    // R9 reversal mid-ramp
    run_case("reverse", 1, 1, 100, 200, 10, 2, 0, -1);
    // R9 request during run-on resumes travel
    run_case("resume", 1, 1, 100, 160, 20, 4, 0, -1);
    // R10 limit adjustments while idle
    run_case("adj_lo", 2, 0, 120, 200, 20, -1, 0, -1);
    run_case("adj_lo2", 2, 0, 120, 190, 20, -1, 0, -1);
    run_case("open190", 1, 1, 120, 190, 40, -1, 0, -1);
    run_case("adj_hi", 2, 0, 120, 170, 40, -1, 0, -1);
    // R9 both requests: closing wins; R2 limits pulled into the window
    run_case("both", 3, 0, 50, 250, 40, -1, 0, 1);
    run_case("wide_up", 1, 1, 50, 250, 40, -1, 0, 0);
    // randomized cases
    for (int j = 0; j < 6; j++) begin
      cl = 80 + ($urandom() % 60);
      op = 160 + ($urandom() % 70);
      st = 8 + ($urandom() % 33);
      up = 1'($urandom() % 2);
      evf = int'($urandom() % 5) - 1;
      evup = 1'($urandom() % 2);
      sa = int'($urandom() % 3);
      run_case("random", 1, up, cl, op, st, evf, evup, sa);
    end
    done = 1;
    summary();
    $finish;
  end

endmodule